// File: doc/BRIEF.md
# Main Clock Failure Detector with Backup Failover

This block watches a main clock from an independent monitor clock and, when the main clock stops toggling, fails over to an on-chip backup oscillator. A toggle flop in the main-clock domain is carried into the monitor domain through a synchronizer. The block declares the main clock stopped when no change of that toggle is seen for a set number of consecutive monitor cycles.

With detection enabled, a stop event does four things at once. It turns on the backup oscillator. It forces the clock-source selection to the backup. It latches a sticky stop-detected flag. It raises an interrupt level that shares one line with the watchdog request. In low-speed mode the CPU stays on the sub clock and only the peripheral clock moves to the backup.

Software can select the backup directly at any time. After the main clock resumes, software returns to it by clearing the source selection. The select outputs drive an external glitch-free clock multiplexer.

Top module: `clkfail_guard`

## Requirements
- R1: After reset, the status word is 0, the backup enable is 0, and both `cpu_sel_o` and `per_sel_o` are 0 (main clock). `irq_o` then follows only `wdt_irq_i`.
- R2: Writing the source-select bit to 1 sets `bkup_en_o` to 1. Outside low-speed mode it also sets `cpu_sel_o` and `per_sel_o` to 1 (backup). Status bit 1 reads back the source select.
- R3: Status bit 3 (main stopped) rises after `MISS_LIMIT` consecutive monitor cycles without a main-clock toggle. It clears by itself once toggling returns, and it stays 0 while the main clock runs.
- R4: With detect enable (status bit 0) at 1, a stop sets status bit 2 (stop detected), forces the source select to 1 and turns on the backup. With detect enable at 0, a stop changes neither bit 2 nor the source select.
- R5: In low-speed mode (status bit 4), `cpu_sel_o` is 2 (sub clock). `per_sel_o` follows the source select, and that includes a failover.
- R6: `irq_o` is the OR of `wdt_irq_i` with (stop detected AND detect enable). Software tells the two sources apart by status bit 2.
- R7: The stop-detected flag stays set until a `flag_clr_i` pulse clears it. If a stop event lands in the same cycle as the clear, the flag is set.
- R8: `wake_o` is `wait_mode_i` AND `ext_wake_i`. A failure never wakes the device, but its request level on `irq_o` holds through wait mode so that it is pending when wait mode ends.
- R9: After the main clock resumes, writing the source select to 0 returns both selects to 0 and turns the backup off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; all control state lives here |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk | input | 1 | Main clock under watch |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_det_en_i | input | 1 | Write data: detect enable |
| ctl_src_sel_i | input | 1 | Write data: source select (1 = backup) |
| ctl_low_speed_i | input | 1 | Write data: low-speed mode |
| flag_clr_i | input | 1 | Clears the stop-detected flag |
| wait_mode_i | input | 1 | Device is in wait mode |
| ext_wake_i | input | 1 | Other interrupt able to end wait mode |
| wdt_irq_i | input | 1 | Watchdog request sharing the vector |
| stat_o | output | 5 | {low_speed, main_stopped, stop_det, src_sel, det_en} |
| irq_o | output | 1 | Shared failure/watchdog request level |
| wake_o | output | 1 | Wake request out of wait mode |
| bkup_en_o | output | 1 | Backup oscillator run enable |
| cpu_sel_o | output | 2 | CPU clock select: 0 main, 1 backup, 2 sub |
| per_sel_o | output | 2 | Peripheral clock select: 0 main, 1 backup |

## Verification
The bench builds the block with its default `MISS_LIMIT` of 4 and two synchronizer stages. It runs the main clock at a period that does not divide the monitor period, so toggles reach the monitor domain at irregular phases. At these values a stop is declared within a few monitor cycles, and the bench's 20-cycle waits cover detection, recovery and failover in every mode. The same waits also show that a running clock never trips the detector.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_BKUP = 2'd1,
    SRC_SUB  = 2'd2
  } clk_src_e;

  typedef struct packed {
    logic low_speed;
    logic main_stopped;
    logic stop_det;
    logic src_sel;
    logic det_en;
  } cfd_stat_t;

  localparam int STAT_W = 5;
endpackage

// File: rtl/cfd_rst_sync.sv
module cfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/cfd_toggle.sv
module cfd_toggle (
  input  logic clk,
  input  logic rst_n,
  output logic tgl_o
);
  logic tgl_q;
  logic tgl_d;

  always_comb tgl_d = ~tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign tgl_o = tgl_q;
endmodule

// File: rtl/cfd_sync.sv
module cfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cfd_miss_mon.sv
module cfd_miss_mon #(
  parameter int MISS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_sync_i,
  output logic stopped_o,
  output logic stop_rise_o
);
  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(MISS_LIMIT);

  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stopped_q, stopped_d;
  logic          seen_edge;

  always_comb begin
    seen_edge = tgl_sync_i ^ prev_q;
    prev_d    = tgl_sync_i;
    if (seen_edge)         cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
    stopped_d   = (cnt_d == LIM);
    stop_rise_o = stopped_d & ~stopped_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      cnt_q     <= '0;
      stopped_q <= 1'b0;
    end else begin
      prev_q    <= prev_d;
      cnt_q     <= cnt_d;
      stopped_q <= stopped_d;
    end
  end

  assign stopped_o = stopped_q;
endmodule

// File: rtl/cfd_ctrl.sv
module cfd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we_i,
  input  logic ctl_det_en_i,
  input  logic ctl_src_sel_i,
  input  logic ctl_low_speed_i,
  input  logic flag_clr_i,
  input  logic stop_rise_i,
  output logic det_en_o,
  output logic src_sel_o,
  output logic low_speed_o,
  output logic stop_det_o
);
  logic det_en_q, det_en_d;
  logic src_sel_q, src_sel_d;
  logic low_speed_q, low_speed_d;
  logic stop_det_q, stop_det_d;
  logic fail_evt;

  always_comb begin
    fail_evt    = stop_rise_i & det_en_q;
    det_en_d    = ctl_we_i ? ctl_det_en_i    : det_en_q;
    low_speed_d = ctl_we_i ? ctl_low_speed_i : low_speed_q;
    src_sel_d   = ctl_we_i ? ctl_src_sel_i   : src_sel_q;
    if (fail_evt) src_sel_d = 1'b1;
    stop_det_d = stop_det_q;
    if (flag_clr_i) stop_det_d = 1'b0;
    if (fail_evt)   stop_det_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_en_q    <= 1'b0;
      src_sel_q   <= 1'b0;
      low_speed_q <= 1'b0;
      stop_det_q  <= 1'b0;
    end else begin
      det_en_q    <= det_en_d;
      src_sel_q   <= src_sel_d;
      low_speed_q <= low_speed_d;
      stop_det_q  <= stop_det_d;
    end
  end

  assign det_en_o    = det_en_q;
  assign src_sel_o   = src_sel_q;
  assign low_speed_o = low_speed_q;
  assign stop_det_o  = stop_det_q;
endmodule

// File: rtl/clkfail_guard.sv
module clkfail_guard
  import cfd_pkg::*;
#(
  parameter int MISS_LIMIT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_clk,
  input  logic              ctl_we_i,
  input  logic              ctl_det_en_i,
  input  logic              ctl_src_sel_i,
  input  logic              ctl_low_speed_i,
  input  logic              flag_clr_i,
  input  logic              wait_mode_i,
  input  logic              ext_wake_i,
  input  logic              wdt_irq_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              bkup_en_o,
  output logic [1:0]        cpu_sel_o,
  output logic [1:0]        per_sel_o
);
  logic mon_rst_n, main_rst_n;
  logic tgl_main, tgl_sync;
  logic stopped, stop_rise;
  logic det_en, src_sel, low_speed, stop_det;
  cfd_stat_t st;
  clk_src_e  per_src, cpu_src;

  cfd_rst_sync #(.STAGES(2)) u_rs_mon (
    .clk(clk), .arst_n(rst_n), .rst_n_o(mon_rst_n));
  cfd_rst_sync #(.STAGES(2)) u_rs_main (
    .clk(main_clk), .arst_n(rst_n), .rst_n_o(main_rst_n));

  cfd_toggle u_tgl (.clk(main_clk), .rst_n(main_rst_n), .tgl_o(tgl_main));

  cfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(mon_rst_n), .d_i(tgl_main), .q_o(tgl_sync));

  cfd_miss_mon #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
    .clk(clk), .rst_n(mon_rst_n), .tgl_sync_i(tgl_sync),
    .stopped_o(stopped), .stop_rise_o(stop_rise));

  cfd_ctrl u_ctrl (
    .clk(clk), .rst_n(mon_rst_n),
    .ctl_we_i(ctl_we_i), .ctl_det_en_i(ctl_det_en_i),
    .ctl_src_sel_i(ctl_src_sel_i), .ctl_low_speed_i(ctl_low_speed_i),
    .flag_clr_i(flag_clr_i), .stop_rise_i(stop_rise),
    .det_en_o(det_en), .src_sel_o(src_sel),
    .low_speed_o(low_speed), .stop_det_o(stop_det));

  always_comb begin
    st.low_speed    = low_speed;
    st.main_stopped = stopped;
    st.stop_det     = stop_det;
    st.src_sel      = src_sel;
    st.det_en       = det_en;
    per_src = src_sel ? SRC_BKUP : SRC_MAIN;
    cpu_src = low_speed ? SRC_SUB : per_src;
  end

  assign stat_o    = st;
  assign per_sel_o = per_src;
  assign cpu_sel_o = cpu_src;
  assign bkup_en_o = src_sel;
  assign irq_o     = wdt_irq_i | (stop_det & det_en);
  assign wake_o    = wait_mode_i & ext_wake_i;
endmodule

// File: rtl/clkfail_guard_chk.sv
module clkfail_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] stat_o,
  input logic       irq_o,
  input logic       wake_o,
  input logic       ext_wake_i,
  input logic       flag_clr_i,
  input logic       bkup_en_o,
  input logic [1:0] cpu_sel_o,
  input logic [1:0] per_sel_o
);
  AST_FAIL_FORCES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[2]) |-> (stat_o[1] && bkup_en_o)); // R4
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[2] && stat_o[0]) |-> irq_o); // R6
  AST_NO_FAIL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wake_i |-> !wake_o); // R8
  AST_LOWSPD_CPU_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[4] |-> (cpu_sel_o == 2'd2)); // R5
  AST_BKUP_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel_o == 2'd1) |-> bkup_en_o); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[2] && !flag_clr_i) |=> stat_o[2]); // R7
endmodule

bind clkfail_guard clkfail_guard_chk u_chk (.*);

// File: tb/tb_clkfail_guard.sv
module tb_clkfail_guard;
  typedef struct {
    string       req;
    logic [11:0] exp;
  } sb_item_t;

  logic clk = 1'b0;
  logic main_clk = 1'b0;
  logic main_run = 1'b1;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_det = 0, ctl_sel = 0, ctl_ls = 0;
  logic flag_clr = 0, wait_mode = 0, ext_wake = 0, wdt_irq = 0;
  logic [4:0] stat;
  logic irq, wake, bkup;
  logic [1:0] cpu_sel, per_sel;

  sb_item_t sb_q[$];
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;
  initial forever begin
    #15;
    if (main_run) main_clk = ~main_clk;
  end

  clkfail_guard dut (
    .clk(clk), .rst_n(rst_n), .main_clk(main_clk),
    .ctl_we_i(ctl_we), .ctl_det_en_i(ctl_det), .ctl_src_sel_i(ctl_sel),
    .ctl_low_speed_i(ctl_ls), .flag_clr_i(flag_clr),
    .wait_mode_i(wait_mode), .ext_wake_i(ext_wake), .wdt_irq_i(wdt_irq),
    .stat_o(stat), .irq_o(irq), .wake_o(wake), .bkup_en_o(bkup),
    .cpu_sel_o(cpu_sel), .per_sel_o(per_sel));

  function automatic logic [11:0] mk(logic i, logic w, logic b,
                                     logic [1:0] c, logic [1:0] p,
                                     logic [4:0] s);
    return {i, w, b, c, p, s};
  endfunction

  // monitor: pops expected items and compares mid-cycle
  initial forever begin
    @(posedge clk);
    #5;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      logic [11:0] act;
      it  = sb_q.pop_front();
      act = {irq, wake, bkup, cpu_sel, per_sel, stat};
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %b expected %b", it.req, act, it.exp);
      end
    end
  end

  task automatic chk(string req, logic [11:0] e);
    sb_item_t it;
    it.req = req;
    it.exp = e;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic wr(logic ls, logic sel, logic en);
    @(negedge clk);
    ctl_ls = ls; ctl_sel = sel; ctl_det = en; ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1;
    idle(6);
    chk("R1 reset state", mk(0,0,0,2'd0,2'd0,5'b00000));
    wdt_irq = 1;
    idle(1);
    chk("R1 irq from watchdog only", mk(1,0,0,2'd0,2'd0,5'b00000));
    wdt_irq = 0;
    idle(20);
    chk("R3 running clock not stopped", mk(0,0,0,2'd0,2'd0,5'b00000));

    wr(0,1,0);
    chk("R2 software selects backup", mk(0,0,1,2'd1,2'd1,5'b00010));
    wr(0,0,0);
    chk("R9 back to main", mk(0,0,0,2'd0,2'd0,5'b00000));

    main_run = 0;
    idle(20);
    chk("R3 stop seen, R4 no failover when disabled", mk(0,0,0,2'd0,2'd0,5'b01000));
    main_run = 1;
    idle(10);
    chk("R3 stop status self-clears", mk(0,0,0,2'd0,2'd0,5'b00000));

    wr(0,0,1);
    main_run = 0;
    idle(20);
    chk("R4 failover with R6 irq", mk(1,0,1,2'd1,2'd1,5'b01111));
    wdt_irq = 1;
    idle(1);
    chk("R6 shared line, flag tells source", mk(1,0,1,2'd1,2'd1,5'b01111));
    wdt_irq = 0;

    wait_mode = 1;
    idle(2);
    chk("R8 failure does not wake", mk(1,0,1,2'd1,2'd1,5'b01111));
    ext_wake = 1;
    idle(1);
    chk("R8 other event wakes, irq pending", mk(1,1,1,2'd1,2'd1,5'b01111));
    wait_mode = 0; ext_wake = 0;
    idle(10);
    chk("R7 flag sticky", mk(1,0,1,2'd1,2'd1,5'b01111));
    clr_flag();
    chk("R7 flag cleared by software", mk(0,0,1,2'd1,2'd1,5'b01011));

    main_run = 1;
    idle(10);
    chk("R3 resume clears stopped", mk(0,0,1,2'd1,2'd1,5'b00011));
    wr(0,0,1);
    chk("R9 software returns to main", mk(0,0,0,2'd0,2'd0,5'b00001));

    wr(1,0,1);
    chk("R5 low-speed cpu on sub", mk(0,0,0,2'd2,2'd0,5'b10001));
    main_run = 0;
    idle(20);
    chk("R5 low-speed failover moves peripheral only", mk(1,0,1,2'd2,2'd1,5'b11111));
    main_run = 1;
    idle(10);
    clr_flag();
    wr(0,0,0);
    chk("R9 all back to main", mk(0,0,0,2'd0,2'd0,5'b00000));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule